// File: doc/BRIEF.md
# Serial Programming Command Front End

This block is the target-side receiver for a two-wire programming link. An external programmer drives a slow programming clock and a shared data line. The block runs on a much faster system clock, oversamples both wires and finds the clock edges. It gathers six-bit commands and turns each recognised command into a one-cycle strobe for the memory controller behind it.

Two commands carry a data frame. A load frame delivers a word that the block hands to the controller. A read frame returns a word that the controller supplies. A frame is sixteen programming-clock cycles long: a start cycle, fourteen data cycles sent least-significant bit first, and a stop cycle. The core word is twelve bits, so the two upper bits of the fourteen-bit field are discarded on load and returned as ones on read. The block drives the data line only during the data cycles of a read frame.

A mode-enable input stands in for high-voltage mode detection. Dropping it abandons any command or frame in progress and releases the line.

Top module: `tw_prog_slave`

## Requirements
- R1: A command consists of six programming-clock cycles. One bit is taken from the data line at each falling edge of the programming clock, and the first bit received is bit 0 of the command.
- R2: Only command bits [3:0] are decoded, and bits [5:4] have no effect. The codes are 0x2 load, 0x4 read, 0x6 increment (`inc_addr`), 0x8 begin (`begin_prog`), 0xE end (`end_prog`) and 0x9 erase (`bulk_erase`). Each strobe is high for exactly one system-clock cycle per command.
- R3: Any other code raises no strobe and starts no frame. The next six programming-clock cycles are taken as a fresh command.
- R4: After a load command, the falling edges of frame cycles 2 to 15 deliver data bits 0 to 13 in that order. After the falling edge of cycle 16, `ld_valid` pulses for one cycle with `ld_word` equal to data bits [11:0]. Bits 12 and 13 are discarded, and `ld_valid` does not pulse before cycle 16.
- R5: After a read command, the block takes `rd_word` as the 14-bit field {2'b11, rd_word}. It drives field bit k-2 on `pdat_out` from the rising edge of frame cycle k, for k from 2 to 15. `pdat_out` changes only on a detected rising edge.
- R6: `pdat_oe` rises at the rising edge of read-frame cycle 2 and falls at the rising edge of cycle 16. It is low at all other times, including the whole of a read frame's start cycle and every load frame.
- R7: While `mode_en` is low, the block returns to command-idle and holds `pdat_oe` low from the next cycle onward. A frame that is interrupted raises no `ld_valid`, even when the disable arrives in the same cycle as the final falling edge. After `mode_en` returns high, the next six programming-clock cycles are parsed as a command.
- R8: At most one of `ld_valid`, `inc_addr`, `begin_prog`, `end_prog` and `bulk_erase` is high in any cycle.
- R9: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Programming mode enable |
| pclk_in | input | 1 | Programming clock from the external programmer |
| pdat_in | input | 1 | Data line, input side |
| pdat_out | output | 1 | Data line, output value |
| pdat_oe | output | 1 | Data line output enable |
| rd_word | input | CORE_W | Word returned by a read frame |
| ld_word | output | CORE_W | Word delivered by a load frame |
| ld_valid | output | 1 | One-cycle pulse: `ld_word` is valid |
| inc_addr | output | 1 | Increment-address strobe |
| begin_prog | output | 1 | Begin-programming strobe |
| end_prog | output | 1 | End-programming strobe |
| bulk_erase | output | 1 | Bulk-erase strobe |

## Verification
The collision that matters is between the last falling edge of a load frame, which would fire `ld_valid`, and the removal of `mode_en`. The bench lowers the programming clock and then drops `mode_en` exactly two system cycles later. That lands the disable on the same edge at which the synchronised falling edge is acted on. Abort must win: the load count stays unchanged, and a command sent after re-enabling must decode normally. A second case drops the enable in the middle of a read frame and checks that the data line is released.

// File: rtl/tw_prog_pkg.sv
package tw_prog_pkg;

   localparam int CMD_BITS  = 6;
   localparam int CODE_BITS = 4;

   typedef enum logic [2:0] {
      CMD_NONE  = 3'd0,
      CMD_LOAD  = 3'd1,
      CMD_READ  = 3'd2,
      CMD_INC   = 3'd3,
      CMD_BEGIN = 3'd4,
      CMD_END   = 3'd5,
      CMD_ERASE = 3'd6
   } cmd_e;

   localparam logic [CODE_BITS-1:0] CODE_LOAD  = 4'h2;
   localparam logic [CODE_BITS-1:0] CODE_READ  = 4'h4;
   localparam logic [CODE_BITS-1:0] CODE_INC   = 4'h6;
   localparam logic [CODE_BITS-1:0] CODE_BEGIN = 4'h8;
   localparam logic [CODE_BITS-1:0] CODE_END   = 4'hE;
   localparam logic [CODE_BITS-1:0] CODE_ERASE = 4'h9;

   function automatic cmd_e decode_cmd(input logic [CODE_BITS-1:0] code);
      cmd_e r;
      case (code)
         CODE_LOAD:  r = CMD_LOAD;
         CODE_READ:  r = CMD_READ;
         CODE_INC:   r = CMD_INC;
         CODE_BEGIN: r = CMD_BEGIN;
         CODE_END:   r = CMD_END;
         CODE_ERASE: r = CMD_ERASE;
         default:    r = CMD_NONE;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tw_prog_sync.sv
module tw_prog_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_clk,
   input  logic pin_dat,
   output logic rise,
   output logic fall,
   output logic dat
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tw_prog_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ck_q;
   logic [STAGES-1:0] dt_q;
   logic              ck_prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ck_q[g] <= 1'b0;
               dt_q[g] <= 1'b0;
            end else begin
               ck_q[g] <= pin_clk;
               dt_q[g] <= pin_dat;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ck_q[g] <= 1'b0;
               dt_q[g] <= 1'b0;
            end else begin
               ck_q[g] <= ck_q[g-1];
               dt_q[g] <= dt_q[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ck_prev <= 1'b0;
      else        ck_prev <= ck_q[STAGES-1];
   end

   assign rise = ck_q[STAGES-1] & ~ck_prev;
   assign fall = ~ck_q[STAGES-1] & ck_prev;
   assign dat  = dt_q[STAGES-1];

endmodule

// File: rtl/tw_prog_cmd.sv
module tw_prog_cmd
   import tw_prog_pkg::*;
#(
   parameter int CMD_W = CMD_BITS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic listen,
   input  logic fall,
   input  logic dat,
   output cmd_e cmd_q
);

   localparam int CNT_W = $clog2(CMD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

   if (CMD_W < CODE_BITS + 1) begin : g_bad_cmd
      $error("tw_prog_cmd: CMD_W must exceed the decoded code width");
   end

   logic [CMD_W-2:0] sh;
   logic [CMD_W-1:0] nxt;
   logic [CNT_W-1:0] cnt;

   assign nxt = {dat, sh};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         cnt   <= '0;
         cmd_q <= CMD_NONE;
      end else if (clr) begin
         sh    <= '0;
         cnt   <= '0;
         cmd_q <= CMD_NONE;
      end else begin
         cmd_q <= CMD_NONE;
         if (listen && fall) begin
            sh <= nxt[CMD_W-1:1];
            if (cnt == LAST) begin
               cnt   <= '0;
               cmd_q <= decode_cmd(nxt[CODE_BITS-1:0]);
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/tw_prog_frame.sv
module tw_prog_frame #(
   parameter int DATA_W = 14,
   parameter int CORE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              start_load,
   input  logic              start_read,
   input  logic              rise,
   input  logic              fall,
   input  logic              dat,
   input  logic [CORE_W-1:0] rd_word,
   output logic              busy,
   output logic              rd_act,
   output logic              oe,
   output logic              dout,
   output logic              ld_valid,
   output logic [CORE_W-1:0] ld_word
);

   localparam int FRAME_LEN = DATA_W + 2;
   localparam int PAD       = DATA_W - CORE_W;
   localparam int CNT_W     = $clog2(FRAME_LEN);
   localparam logic [CNT_W-1:0] C_FIRST = CNT_W'(1);
   localparam logic [CNT_W-1:0] C_LASTD = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] C_STOP  = CNT_W'(FRAME_LEN - 1);

   if (CORE_W > DATA_W) begin : g_bad_width
      $error("tw_prog_frame: CORE_W must not exceed DATA_W");
   end

   typedef enum logic [1:0] {F_IDLE, F_LOAD, F_READ} fstate_e;

   fstate_e           state;
   logic [CNT_W-1:0]  cyc;
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] rd_frame;

   if (PAD > 0) begin : g_pad
      assign rd_frame = {{PAD{1'b1}}, rd_word};
   end else begin : g_nopad
      assign rd_frame = rd_word;
   end

   logic in_data;
   assign in_data = (cyc >= C_FIRST) && (cyc <= C_LASTD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= F_IDLE;
         cyc      <= '0;
         sh       <= '0;
         oe       <= 1'b0;
         dout     <= 1'b0;
         ld_valid <= 1'b0;
         ld_word  <= '0;
      end else if (clr) begin
         state    <= F_IDLE;
         cyc      <= '0;
         sh       <= '0;
         oe       <= 1'b0;
         dout     <= 1'b0;
         ld_valid <= 1'b0;
      end else begin
         ld_valid <= 1'b0;
         case (state)
            F_IDLE: begin
               cyc <= '0;
               if (start_load) begin
                  state <= F_LOAD;
                  sh    <= '0;
               end else if (start_read) begin
                  state <= F_READ;
                  sh    <= rd_frame;
               end
            end
            F_LOAD: begin
               if (fall) begin
                  if (in_data) sh <= {dat, sh[DATA_W-1:1]};
                  if (cyc == C_STOP) begin
                     state    <= F_IDLE;
                     cyc      <= '0;
                     ld_valid <= 1'b1;
                     ld_word  <= sh[CORE_W-1:0];
                  end else begin
                     cyc <= cyc + 1'b1;
                  end
               end
            end
            F_READ: begin
               if (rise) begin
                  if (in_data) begin
                     oe   <= 1'b1;
                     dout <= sh[0];
                     sh   <= {1'b0, sh[DATA_W-1:1]};
                  end else if (cyc == C_STOP) begin
                     oe   <= 1'b0;
                     dout <= 1'b0;
                  end
               end
               if (fall) begin
                  if (cyc == C_STOP) begin
                     state <= F_IDLE;
                     cyc   <= '0;
                  end else begin
                     cyc <= cyc + 1'b1;
                  end
               end
            end
            default: state <= F_IDLE;
         endcase
      end
   end

   assign busy   = (state != F_IDLE);
   assign rd_act = (state == F_READ);

endmodule

// File: rtl/tw_prog_slave.sv
module tw_prog_slave
   import tw_prog_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 14,
   parameter int CORE_W      = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_en,
   input  logic              pclk_in,
   input  logic              pdat_in,
   output logic              pdat_out,
   output logic              pdat_oe,
   input  logic [CORE_W-1:0] rd_word,
   output logic [CORE_W-1:0] ld_word,
   output logic              ld_valid,
   output logic              inc_addr,
   output logic              begin_prog,
   output logic              end_prog,
   output logic              bulk_erase
);

   logic rise_w;
   logic fall_w;
   logic dat_w;
   logic clr_w;
   logic busy_w;
   logic rd_act_w;
   cmd_e cmd_w;

   assign clr_w = ~mode_en;

   tw_prog_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_clk (pclk_in),
      .pin_dat (pdat_in),
      .rise    (rise_w),
      .fall    (fall_w),
      .dat     (dat_w)
   );

   tw_prog_cmd #(.CMD_W(CMD_BITS)) i_cmd (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_w),
      .listen (~busy_w),
      .fall   (fall_w),
      .dat    (dat_w),
      .cmd_q  (cmd_w)
   );

   tw_prog_frame #(.DATA_W(DATA_W), .CORE_W(CORE_W)) i_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr_w),
      .start_load (cmd_w == CMD_LOAD),
      .start_read (cmd_w == CMD_READ),
      .rise       (rise_w),
      .fall       (fall_w),
      .dat        (dat_w),
      .rd_word    (rd_word),
      .busy       (busy_w),
      .rd_act     (rd_act_w),
      .oe         (pdat_oe),
      .dout       (pdat_out),
      .ld_valid   (ld_valid),
      .ld_word    (ld_word)
   );

   assign inc_addr   = (cmd_w == CMD_INC);
   assign begin_prog = (cmd_w == CMD_BEGIN);
   assign end_prog   = (cmd_w == CMD_END);
   assign bulk_erase = (cmd_w == CMD_ERASE);

endmodule

// File: rtl/tw_prog_slave_chk.sv
module tw_prog_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic mode_en,
   input logic rise_evt,
   input logic rd_act,
   input logic frame_busy,
   input logic pdat_oe,
   input logic pdat_out,
   input logic ld_valid,
   input logic inc_addr,
   input logic begin_prog,
   input logic end_prog,
   input logic bulk_erase
);

   AST_OE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      pdat_oe |-> rd_act); // R6

   AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ld_valid, inc_addr, begin_prog, end_prog, bulk_erase})); // R8

   AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_en |=> (!pdat_oe && !frame_busy)); // R7

   AST_OE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdat_oe) |-> $past(rise_evt)); // R5

   AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pdat_oe && $past(pdat_oe) && !$past(rise_evt)) |-> $stable(pdat_out)); // R5

   AST_LOAD_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> !frame_busy); // R4

endmodule

bind tw_prog_slave tw_prog_slave_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_en    (mode_en),
   .rise_evt   (rise_w),
   .rd_act     (rd_act_w),
   .frame_busy (busy_w),
   .pdat_oe    (pdat_oe),
   .pdat_out   (pdat_out),
   .ld_valid   (ld_valid),
   .inc_addr   (inc_addr),
   .begin_prog (begin_prog),
   .end_prog   (end_prog),
   .bulk_erase (bulk_erase)
);

// File: tb/test_tw_prog_slave.sv
`timescale 1ns/1ps
module test_tw_prog_slave;

   localparam int CORE_W = 12;
   localparam int HALF   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mode_en = 1'b0;
   logic              pclk_in = 1'b0;
   logic              pdat_in = 1'b0;
   logic              pdat_out;
   logic              pdat_oe;
   logic [CORE_W-1:0] rd_word = '0;
   logic [CORE_W-1:0] ld_word;
   logic              ld_valid;
   logic              inc_addr;
   logic              begin_prog;
   logic              end_prog;
   logic              bulk_erase;

   always #2 clk = ~clk;

   tw_prog_slave i_tw_prog_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_en    (mode_en),
      .pclk_in    (pclk_in),
      .pdat_in    (pdat_in),
      .pdat_out   (pdat_out),
      .pdat_oe    (pdat_oe),
      .rd_word    (rd_word),
      .ld_word    (ld_word),
      .ld_valid   (ld_valid),
      .inc_addr   (inc_addr),
      .begin_prog (begin_prog),
      .end_prog   (end_prog),
      .bulk_erase (bulk_erase)
   );

   int n_checks = 0;
   int n_errors = 0;
   int n_ld = 0, n_inc = 0, n_beg = 0, n_end = 0, n_era = 0;
   logic [CORE_W-1:0] last_ld = '0;
   bit done = 1'b0;

   always @(posedge clk) begin
      if (ld_valid)   begin n_ld++; last_ld = ld_word; end
      if (inc_addr)   n_inc++;
      if (begin_prog) n_beg++;
      if (end_prog)   n_end++;
      if (bulk_erase) n_era++;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pc_cycle(input logic d);
      @(negedge clk);
      pclk_in = 1'b1;
      pdat_in = d;
      repeat (HALF) @(negedge clk);
      pclk_in = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic send_cmd(input logic [5:0] c);
      for (int i = 0; i < 6; i++) pc_cycle(c[i]);
   endtask

   function automatic logic [31:0] counts();
      return {n_ld[5:0], n_inc[5:0], n_beg[5:0], n_end[5:0], n_era[5:0], 2'b00};
   endfunction

   task automatic t_reset();
      check("R9 outputs after reset",
            {25'd0, pdat_oe, pdat_out, ld_valid, inc_addr, begin_prog, end_prog, bulk_erase}, 32'd0);
   endtask

   task automatic t_commands();
      logic [31:0] c0;
      c0 = counts();
      send_cmd(6'h06);
      check("R1 R2 increment strobe", 32'(n_inc), 32'(1));
      send_cmd(6'h08);
      check("R2 begin strobe", 32'(n_beg), 32'(1));
      send_cmd(6'h0E);
      check("R2 end strobe", 32'(n_end), 32'(1));
      send_cmd(6'h09);
      check("R2 erase strobe", 32'(n_era), 32'(1));
      send_cmd(6'h36);
      check("R2 top bits ignored, increment", 32'(n_inc), 32'(2));
      send_cmd(6'h1E);
      check("R2 top bits ignored, end", 32'(n_end), 32'(2));
      check("R2 no load strobe from plain commands", 32'(n_ld), c0[31:26]);
   endtask

   task automatic t_unknown();
      logic [31:0] c0;
      c0 = counts();
      send_cmd(6'h03);
      send_cmd(6'h0F);
      check("R3 unknown codes give no strobe", counts(), c0);
      check("R3 unknown code leaves pin released", 32'(pdat_oe), 32'd0);
      send_cmd(6'h06);
      check("R3 next command parsed normally", 32'(n_inc), 32'(c0[25:20]) + 32'd1);
   endtask

   task automatic t_load(input logic [13:0] w);
      int base;
      base = n_ld;
      send_cmd(6'h02);
      pc_cycle(1'b0);
      for (int i = 0; i < 14; i++) begin
         pc_cycle(w[i]);
         if (pdat_oe !== 1'b0) begin
            n_errors++;
            $display("FAIL R6 oe during load actual=1 expected=0");
         end
      end
      check("R4 no load pulse before stop cycle", 32'(n_ld), 32'(base));
      pc_cycle(1'b1);
      check("R4 load pulse count", 32'(n_ld), 32'(base + 1));
      check("R4 load word", 32'(last_ld), 32'(w[11:0]));
   endtask

   task automatic t_read(input logic [CORE_W-1:0] w);
      logic [13:0] exp_f;
      logic [13:0] got;
      logic [15:0] oe_seen;
      exp_f = {2'b11, w};
      got = '0;
      rd_word = w;
      send_cmd(6'h04);
      for (int k = 1; k <= 16; k++) begin
         @(negedge clk);
         pclk_in = 1'b1;
         pdat_in = 1'b0;
         repeat (HALF - 1) @(negedge clk);
         oe_seen[k-1] = pdat_oe;
         if (k >= 2 && k <= 15) got[k-2] = pdat_out;
         @(negedge clk);
         pclk_in = 1'b0;
         repeat (HALF) @(negedge clk);
      end
      check("R5 read field", 32'(got), 32'(exp_f));
      check("R6 oe pattern over read frame", 32'(oe_seen), 32'h7FFE);
      check("R6 oe released after frame", 32'(pdat_oe), 32'd0);
   endtask

   task automatic t_abort_load();
      int base;
      base = n_ld;
      send_cmd(6'h02);
      for (int i = 0; i < 15; i++) pc_cycle(i[0]);
      @(negedge clk);
      pclk_in = 1'b1;
      repeat (HALF) @(negedge clk);
      pclk_in = 1'b0;
      @(negedge clk);
      @(negedge clk);
      mode_en = 1'b0;
      repeat (HALF) @(negedge clk);
      check("R7 disable on final edge suppresses load", 32'(n_ld), 32'(base));
      mode_en = 1'b1;
      base = n_inc;
      send_cmd(6'h06);
      check("R7 command after re-enable", 32'(n_inc), 32'(base + 1));
   endtask

   task automatic t_abort_read();
      int base;
      rd_word = 12'hFFF;
      send_cmd(6'h04);
      for (int i = 0; i < 5; i++) pc_cycle(1'b0);
      @(negedge clk);
      pclk_in = 1'b1;
      repeat (HALF) @(negedge clk);
      check("R6 oe high mid read", 32'(pdat_oe), 32'd1);
      mode_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R7 disable releases pin", 32'(pdat_oe), 32'd0);
      pclk_in = 1'b0;
      repeat (HALF) @(negedge clk);
      mode_en = 1'b1;
      base = n_beg;
      send_cmd(6'h08);
      check("R7 idle after read abort", 32'(n_beg), 32'(base + 1));
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      mode_en = 1'b1;
      repeat (3) @(negedge clk);
      t_commands();
      t_unknown();
      t_load(14'h3A5C);
      t_load(14'h0001);
      t_load(14'h2FFF);
      t_read(12'hA53);
      t_read(12'h001);
      t_read(12'h000);
      t_abort_load();
      t_abort_read();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

endmodule